// File: doc/BRIEF.md
# Eight-Line Vectored Interrupt Controller

This block collects interrupt requests from eight input lines and presents them to a processor over a single interrupt output. A rising edge on an input is latched as a pending request. Pending requests pass through a mask. The highest-priority survivor raises the interrupt output, provided it outranks every interrupt that is still being serviced. The processor answers with two acknowledge pulses. The first pulse moves the winning request from the pending set into the in-service set. The second pulse makes the controller put an 8-bit vector on its data output. The vector is a programmable 5-bit base with the 3-bit line number below it.

The acknowledge sequence cannot be aborted once the processor has started it. The request may disappear before the first acknowledge, either because software masked it or because a higher in-service level now blocks it. In that case the controller still answers, using a fixed spurious vector: the base joined to line number 7. No in-service bit is set for a spurious answer. Software can therefore tell a real line-7 interrupt from a spurious one by reading the in-service register. Priority can be rotated by naming the lowest-priority line. The spurious vector does not follow the rotation. Software retires in-service bits with specific or non-specific end-of-interrupt commands through a small register port.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A low-to-high change on `irqIn[i]` sets pending bit i one clock later. An input held high does not set the bit again after it has been serviced.
- R2: On the first acknowledge of a pair, the winning line's pending bit is cleared and its in-service bit is set.
- R3: On the second acknowledge, `vecOut` takes `{base, line}` and `vecValid` is high for exactly the one cycle after that clock edge.
- R4: Priority runs from the line after the configured lowest line, upward with wrap. After reset the lowest line is 7, so line 0 ranks highest.
- R5: `intOut` is high only when an unmasked pending line outranks every set in-service bit.
- R6: If no line qualifies at the first acknowledge, the vector is `{base, 3'd7}`, and the in-service and pending registers are left unchanged.
- R7: The spurious vector uses line number 7 even when priority has been rotated.
- R8: A masked line stays pending but cannot raise `intOut`. It can be serviced once it is unmasked.
- R9: A write to address 1 with bit 4 and bit 3 set clears the in-service bit named by bits 2:0.
- R10: A write to address 1 with bit 4 set and bit 3 clear clears the highest-priority set in-service bit, under the current rotation.
- R11: Reads use address 0 for pending, 1 for in-service, 2 for mask and 3 for {base[7:3], lowest line[2:0]}. Writes use address 2 for mask and 3 for configuration. After reset all reads are 0 except address 3, which reads 0x07.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 8 | Edge-sensitive request lines |
| ackIn | input | 1 | Acknowledge pulse from the processor, two per interrupt |
| intOut | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector supplied after the second acknowledge |
| vecValid | output | 1 | One-cycle strobe marking vecOut |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Combinational read data for regAddr |

## Verification
A request edge shows up in the pending register, and on `intOut`, after the first rising clock edge that sees it. The bench therefore drives on a falling edge and checks on the next falling edge. Writes to the register port, including mask changes and end-of-interrupt commands, act on the following rising edge, and readback is combinational. Each check is made half a cycle after the write. The vector and its strobe come from the edge that takes the second acknowledge. The bench checks them on the falling edge right after that edge, and checks one cycle later that the strobe has dropped.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int NumLines = 8;
  localparam int LineW    = $clog2(NumLines);
  localparam int VecW     = 8;
  localparam int BaseW    = VecW - LineW;
  localparam logic [LineW-1:0] SpurLine = LineW'(NumLines - 1);

  typedef struct packed {
    logic takeWinner;
    logic takeSpurious;
    logic driveVec;
    logic eoiSpecific;
    logic eoiNonSpecific;
    logic wrMask;
    logic wrCfg;
  } ctrlStrobes_t;

  // Returns {found, position} of the first set bit, scanning from line low+1 upward with wrap.
  function automatic logic [LineW:0] firstPos(input logic [NumLines-1:0] v,
                                             input logic [LineW-1:0] low);
    logic found;
    logic [LineW-1:0] pos;
    logic [LineW-1:0] idx;
    found = 1'b0;
    pos   = '0;
    for (int k = 0; k < NumLines; k++) begin
      idx = low + LineW'(1) + LineW'(k);
      if (v[idx] && !found) begin
        found = 1'b1;
        pos   = LineW'(k);
      end
    end
    return {found, pos};
  endfunction
endpackage

// File: rtl/ivc_ctrl.sv
module ivc_ctrl
  import ivc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ackIn,
  input  logic         winValid,
  input  logic         regWe,
  input  logic [1:0]   regAddr,
  input  logic [4:3]   cmdBits,
  output ctrlStrobes_t strb
);
  typedef enum logic {AckFirst, AckSecond} ackPhase_t;
  ackPhase_t phaseQ;

  always_ff @(posedge clk) begin
    if (!rstN) phaseQ <= AckFirst;
    else if (ackIn) phaseQ <= (phaseQ == AckFirst) ? AckSecond : AckFirst;
  end

  always_comb begin
    strb = '0;
    strb.takeWinner     = ackIn && (phaseQ == AckFirst) && winValid;
    strb.takeSpurious   = ackIn && (phaseQ == AckFirst) && !winValid;
    strb.driveVec       = ackIn && (phaseQ == AckSecond);
    strb.eoiSpecific    = regWe && (regAddr == 2'd1) && cmdBits[4] && cmdBits[3];
    strb.eoiNonSpecific = regWe && (regAddr == 2'd1) && cmdBits[4] && !cmdBits[3];
    strb.wrMask         = regWe && (regAddr == 2'd2);
    strb.wrCfg          = regWe && (regAddr == 2'd3);
  end
endmodule

// File: rtl/ivc_datapath.sv
module ivc_datapath
  import ivc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NumLines-1:0] irqIn,
  input  ctrlStrobes_t        strb,
  input  logic [1:0]          regAddr,
  input  logic [VecW-1:0]     regWdata,
  output logic [VecW-1:0]     regRdata,
  output logic                winValid,
  output logic [VecW-1:0]     vecOut,
  output logic                vecValid,
  output logic [NumLines-1:0] irrQ,
  output logic [NumLines-1:0] isrQ,
  output logic [NumLines-1:0] maskQ
);
  logic [NumLines-1:0] irqPrev;
  logic [BaseW-1:0]    baseQ;
  logic [LineW-1:0]    lowQ;
  logic [LineW-1:0]    lineQ;
  logic [LineW:0]      reqHit, isrHit;
  logic [LineW-1:0]    winLine, isrTop;
  logic [NumLines-1:0] irrNext, isrNext, edgeSeen;

  assign reqHit   = firstPos(irrQ & ~maskQ, lowQ);
  assign isrHit   = firstPos(isrQ, lowQ);
  assign winValid = reqHit[LineW] && (!isrHit[LineW] || (reqHit[LineW-1:0] < isrHit[LineW-1:0]));
  assign winLine  = lowQ + LineW'(1) + reqHit[LineW-1:0];
  assign isrTop   = lowQ + LineW'(1) + isrHit[LineW-1:0];

  genvar g;
  generate
    for (g = 0; g < NumLines; g++) begin : gEdge
      assign edgeSeen[g] = irqIn[g] && !irqPrev[g];
    end
  endgenerate

  always_comb begin
    irrNext = irrQ;
    if (strb.takeWinner) irrNext[winLine] = 1'b0;
    irrNext = irrNext | edgeSeen;
    isrNext = isrQ;
    if (strb.eoiSpecific) isrNext[regWdata[LineW-1:0]] = 1'b0;
    if (strb.eoiNonSpecific && isrHit[LineW]) isrNext[isrTop] = 1'b0;
    if (strb.takeWinner) isrNext[winLine] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPrev  <= '0;
      irrQ     <= '0;
      isrQ     <= '0;
      maskQ    <= '0;
      baseQ    <= '0;
      lowQ     <= SpurLine;
      lineQ    <= '0;
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      irqPrev  <= irqIn;
      irrQ     <= irrNext;
      isrQ     <= isrNext;
      vecValid <= strb.driveVec;
      if (strb.wrMask) maskQ <= regWdata[NumLines-1:0];
      if (strb.wrCfg) begin
        baseQ <= regWdata[VecW-1:LineW];
        lowQ  <= regWdata[LineW-1:0];
      end
      if (strb.takeWinner) lineQ <= winLine;
      else if (strb.takeSpurious) lineQ <= SpurLine;
      if (strb.driveVec) vecOut <= {baseQ, lineQ};
    end
  end

  always_comb begin
    case (regAddr)
      2'd0:    regRdata = irrQ;
      2'd1:    regRdata = isrQ;
      2'd2:    regRdata = maskQ;
      default: regRdata = {baseQ, lowQ};
    endcase
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] irqIn,
  input  logic       ackIn,
  output logic       intOut,
  output logic [7:0] vecOut,
  output logic       vecValid,
  input  logic       regWe,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata
);
  ctrlStrobes_t        strb;
  logic                winValid;
  logic [NumLines-1:0] irrQ, isrQ, maskQ;

  ivc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ackIn(ackIn), .winValid(winValid),
    .regWe(regWe), .regAddr(regAddr), .cmdBits(regWdata[4:3]), .strb(strb)
  );

  ivc_datapath u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .strb(strb), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .winValid(winValid),
    .vecOut(vecOut), .vecValid(vecValid), .irrQ(irrQ), .isrQ(isrQ), .maskQ(maskQ)
  );

  assign intOut = winValid;
endmodule

// File: rtl/irq_vector_ctrl_checker.sv
module irq_vector_ctrl_checker (
  input logic       clk,
  input logic       rstN,
  input logic       ackIn,
  input logic       intOut,
  input logic       vecValid,
  input logic       regWe,
  input logic       spurTake,
  input logic [7:0] irr,
  input logic [7:0] isr,
  input logic [7:0] mask
);
  AST_VEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) vecValid |=> !vecValid); // R3
  AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN) vecValid |-> $past(ackIn)); // R3
  AST_INT_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rstN) intOut |-> |(irr & ~mask)); // R8
  AST_ISR_QUIET: assert property (@(posedge clk) disable iff (!rstN) (!ackIn && !regWe) |=> $stable(isr)); // R2
  AST_SPUR_NO_ISR: assert property (@(posedge clk) disable iff (!rstN) (spurTake && !regWe) |=> $stable(isr)); // R6
endmodule

bind irq_vector_ctrl irq_vector_ctrl_checker u_chk (
  .clk(clk), .rstN(rstN), .ackIn(ackIn), .intOut(intOut), .vecValid(vecValid),
  .regWe(regWe), .spurTake(strb.takeSpurious), .irr(irrQ), .isr(isrQ), .mask(maskQ)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic ackIn = 1'b0;
  logic intOut, vecValid;
  logic [7:0] vecOut, regRdata;
  logic regWe = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .ackIn(ackIn), .intOut(intOut),
    .vecOut(vecOut), .vecValid(vecValid), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  task automatic check(input string what, input int got, input int exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", what, got, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic pulseIrq(input logic [7:0] m);
    irqIn = irqIn | m;
    @(negedge clk);
    irqIn = irqIn & ~m;
  endtask

  task automatic ackPair(input string tag, input logic [7:0] expVec);
    ackIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    ackIn = 1'b0;
    check({tag, " vecValid"}, vecValid, 1);
    check({tag, " vector"}, vecOut, expVec);
    @(negedge clk);
    check({tag, " R3 strobe drops"}, vecValid, 0);
  endtask

  task automatic regIs(input string what, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] d;
    readReg(a, d);
    check(what, d, exp);
  endtask

  task automatic testReset();
    check("R11 reset intOut", intOut, 0);
    check("R11 reset vecValid", vecValid, 0);
    regIs("R11 reset pending", 2'd0, 8'h00);
    regIs("R11 reset in-service", 2'd1, 8'h00);
    regIs("R11 reset mask", 2'd2, 8'h00);
    regIs("R11 reset config", 2'd3, 8'h07);
  endtask

  task automatic testEdgeAndAck();
    writeReg(2'd3, 8'h47);
    regIs("R11 config readback", 2'd3, 8'h47);
    irqIn[3] = 1'b1;
    @(negedge clk);
    regIs("R1 edge latched", 2'd0, 8'h08);
    check("R1 intOut raised", intOut, 1);
    ackPair("R3 line3", 8'h43);
    regIs("R2 in-service set", 2'd1, 8'h08);
    regIs("R2 pending cleared", 2'd0, 8'h00);
    repeat (2) @(negedge clk);
    regIs("R1 held level no retrigger", 2'd0, 8'h00);
    irqIn[3] = 1'b0;
  endtask

  task automatic testNesting();
    pulseIrq(8'h20);
    check("R5 lower line blocked by in-service", intOut, 0);
    pulseIrq(8'h02);
    check("R5 higher line nests", intOut, 1);
    ackPair("R4 line1 wins", 8'h41);
    regIs("R2 nested in-service", 2'd1, 8'h0A);
    regIs("R2 line5 still pending", 2'd0, 8'h20);
  endtask

  task automatic testEoi();
    writeReg(2'd1, 8'h10);
    regIs("R10 non-specific clears line1", 2'd1, 8'h08);
    check("R5 still blocked", intOut, 0);
    writeReg(2'd1, 8'h1B);
    regIs("R9 specific clears line3", 2'd1, 8'h00);
    check("R5 unblocked", intOut, 1);
    ackPair("R3 line5", 8'h45);
    writeReg(2'd1, 8'h10);
    regIs("R10 clears last", 2'd1, 8'h00);
  endtask

  task automatic testMaskSpurious();
    pulseIrq(8'h04);
    check("R1 line2 raises", intOut, 1);
    writeReg(2'd2, 8'h04);
    check("R8 masked drops intOut", intOut, 0);
    ackPair("R6 spurious after mask", 8'h47);
    regIs("R6 in-service untouched", 2'd1, 8'h00);
    regIs("R8 masked stays pending", 2'd0, 8'h04);
    writeReg(2'd2, 8'h00);
    check("R8 unmask raises", intOut, 1);
    ackPair("R8 serviced after unmask", 8'h42);
    regIs("R2 line2 in service", 2'd1, 8'h04);
    writeReg(2'd1, 8'h10);
  endtask

  task automatic testGenuine7();
    pulseIrq(8'h80);
    ackPair("R6 genuine line7", 8'h47);
    regIs("R6 genuine line7 sets in-service", 2'd1, 8'h80);
    writeReg(2'd1, 8'h1F);
    regIs("R9 specific clears line7", 2'd1, 8'h00);
  endtask

  task automatic testRotation();
    writeReg(2'd3, 8'h42);
    pulseIrq(8'h12);
    ackPair("R4 rotated line4 beats line1", 8'h44);
    regIs("R4 rotated in-service", 2'd1, 8'h10);
    check("R5 line1 below line4", intOut, 0);
    ackPair("R7 spurious stays line7", 8'h47);
    regIs("R7 in-service unchanged", 2'd1, 8'h10);
    regIs("R6 pending unchanged", 2'd0, 8'h02);
    pulseIrq(8'h08);
    check("R4 line3 top after rotation", intOut, 1);
    ackPair("R4 line3", 8'h43);
    writeReg(2'd1, 8'h10);
    regIs("R10 rotated clears line3", 2'd1, 8'h10);
    writeReg(2'd1, 8'h10);
    check("R5 line1 now eligible", intOut, 1);
    ackPair("R4 line1 rotated", 8'h41);
    pulseIrq(8'h10);
    check("R4 line4 outranks line1", intOut, 1);
    ackPair("R4 line4 nested", 8'h44);
    regIs("R2 rotated nest", 2'd1, 8'h12);
    writeReg(2'd1, 8'h10);
    regIs("R10 clears line4 not line1", 2'd1, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEdgeAndAck();
    testNesting();
    testEoi();
    testMaskSpurious();
    testGenuine7();
    testRotation();
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired: got running expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule